// File: doc/BRIEF.md
# Supervisor reset and watchdog controller

This block supervises a small processor system from a handful of digital status inputs. It holds the processor in reset while an external comparator reports a bad supply. Once the supply recovers, it keeps the reset asserted for a full hold interval, and only then releases it. A watchdog then watches a service input. If the software stops toggling that input, the watchdog issues a fresh reset pulse once per timeout period. The first timeout after any reset always uses the long period. After a service edge, the period follows a select input.

The block also gates a chip-enable request, so memory cannot be selected while the supply is bad. It passes a power-fail comparator flag through to an output, and forces that output low in battery mode. All intervals are counted in steps of a timebase. The default step source is a tick input. When the clock-source select is low, the step source is the rising edges of an external clock input instead, and the intervals then come from a separate set of edge counts. The asynchronous status inputs pass through two-stage synchronizers before use.

Top module: `sup_guard`

## Requirements
- R1: When `supply_ok` falls, `rst_n_out` goes low on the third rising clock edge after the change and stays low while `supply_ok` is low.
- R2: After `supply_ok` returns high, `rst_n_out` stays low for exactly RST_TICKS timebase steps counted from the last edge at which the block still saw the supply as bad. With one step per cycle, it rises on the (RST_TICKS+2)-th edge after the input change. This also applies after the synchronous reset `rst` is released.
- R3: `rst_out` is always the inverse of `rst_n_out`.
- R4: The first watchdog period after any reset release is WD_LONG_TICKS steps, whatever the value of `wd_short_sel`.
- R5: Any edge, rising or falling, of `wd_kick` restarts the watchdog three cycles later. The next period is WD_SHORT_TICKS steps when `wd_short_sel`=1 and WD_LONG_TICKS steps when it is 0. An expiry drives `rst_n_out` low one cycle after the final count.
- R6: An unserviced watchdog produces a reset pulse of the full RST_TICKS length after every period. Each pulse is followed by a new long period.
- R7: With WD_EN=0, no watchdog reset ever occurs.
- R8: With `clk_src_sel`=0, a step is a rising edge of `ext_clk`, and `tick` is ignored. The reset hold time is EXT_RST_EDGES edges and the watchdog long period is EXT_WD_LONG_EDGES edges.
- R9: With `clk_src_sel`=1 and `tick` held low, no step occurs, so a pending reset is held. Stepping resumes on the first edge at which `tick`=1 is sampled.
- R10: `ce_out_n` (active low) copies `ce_in_n` one cycle later while the supply is good. It is forced to 1 on the third edge after `supply_ok` falls.
- R11: `pf_out` follows `pf_cmp` with a three-edge latency, and is forced to 0 while `batt_mode`=1.
- R12: While `rst` is high, the outputs are `rst_n_out`=0, `rst_out`=1, `ce_out_n`=1 and `pf_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Internal timebase step strobe |
| ext_clk | input | 1 | External timebase clock, counted on rising edges |
| clk_src_sel | input | 1 | 1: tick steps, 0: external clock edges |
| supply_ok | input | 1 | Supply-good flag from the external comparator |
| batt_mode | input | 1 | Battery mode is active |
| pf_cmp | input | 1 | Power-fail comparator flag, 1 = above threshold |
| wd_kick | input | 1 | Watchdog service, any edge counts |
| wd_short_sel | input | 1 | 1: short watchdog period after a service edge |
| ce_in_n | input | 1 | Active-low chip-enable request |
| rst_n_out | output | 1 | Active-low processor reset |
| rst_out | output | 1 | Active-high processor reset |
| ce_out_n | output | 1 | Gated active-low chip enable |
| pf_out | output | 1 | Power-fail output |

## Verification
Each result has a fixed latency measured from the negedge at which the bench drives the input. A supply drop shows on `rst_n_out` three edges later. A release follows RST_TICKS+2 edges after the supply rises, with one step per cycle. A watchdog fall comes WD_period+1 edges after the counter restart, and that restart lands three edges after a service toggle or on the release edge itself. The chip-enable output is due one edge after its input, and the power-fail output three edges after its inputs. The driver computes each expected reset edge as an absolute cycle number and pushes it into a queue. The monitor samples at the falling clock edge, pops an entry for every change on `rst_n_out`, and compares the cycle and the level, so an early, late or unexpected edge is reported. In external-clock mode the bench counts the edges it generates, and checks the reset level after one edge fewer than the interval and again after the final edge.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_INT = 1'b1
  } tsrc_e;

  localparam int unsigned SYNC_W  = 7;
  localparam int unsigned IX_SUP  = 0;
  localparam int unsigned IX_BATT = 1;
  localparam int unsigned IX_PF   = 2;
  localparam int unsigned IX_KICK = 3;
  localparam int unsigned IX_EXT  = 4;
  localparam int unsigned IX_SRC  = 5;
  localparam int unsigned IX_SEL  = 6;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/sup_timebase.sv
module sup_timebase
  import sup_pkg::*;
#(
  parameter int unsigned CW             = 12,
  parameter int unsigned RST_TICKS      = 200,
  parameter int unsigned WD_LONG_TICKS  = 1600,
  parameter int unsigned WD_SHORT_TICKS = 100,
  parameter int unsigned EXT_RST_EDGES      = 1024,
  parameter int unsigned EXT_WD_LONG_EDGES  = 8192,
  parameter int unsigned EXT_WD_SHORT_EDGES = 512
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ext_lvl,
  input  tsrc_e         src,
  output logic          step,
  output logic [CW-1:0] lim_rst,
  output logic [CW-1:0] lim_long,
  output logic [CW-1:0] lim_short
);

  localparam logic [CW-1:0] I_RST   = CW'(RST_TICKS);
  localparam logic [CW-1:0] I_LONG  = CW'(WD_LONG_TICKS);
  localparam logic [CW-1:0] I_SHORT = CW'(WD_SHORT_TICKS);
  localparam logic [CW-1:0] E_RST   = CW'(EXT_RST_EDGES);
  localparam logic [CW-1:0] E_LONG  = CW'(EXT_WD_LONG_EDGES);
  localparam logic [CW-1:0] E_SHORT = CW'(EXT_WD_SHORT_EDGES);

  logic ext_prev_q;
  logic ext_rise;

  always_ff @(posedge clk) begin
    if (rst) ext_prev_q <= 1'b0;
    else     ext_prev_q <= ext_lvl;
  end

  assign ext_rise = ext_lvl & ~ext_prev_q;

  always_comb begin
    if (src == SRC_INT) begin
      step      = tick;
      lim_rst   = I_RST;
      lim_long  = I_LONG;
      lim_short = I_SHORT;
    end else begin
      step      = ext_rise;
      lim_rst   = E_RST;
      lim_long  = E_LONG;
      lim_short = E_SHORT;
    end
  end

endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          sup_ok,
  input  logic          wd_fire,
  input  logic [CW-1:0] lim_rst,
  output logic          rst_n_q,
  output logic          rst_q
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (!sup_ok || wd_fire)           cnt_nxt = lim_rst;
    else if (step && cnt_q != '0)     cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= lim_rst;
      rst_n_q <= 1'b0;
      rst_q   <= 1'b1;
    end else begin
      cnt_q   <= cnt_nxt;
      rst_n_q <= (cnt_nxt == '0);
      rst_q   <= (cnt_nxt != '0);
    end
  end

  // R1: a bad supply seen by the generator asserts reset on the next edge
  a_r1_supply_low_holds: assert property (@(posedge clk) disable iff (rst)
    !sup_ok |=> !rst_n_q);

  // R2: release only after the hold counter has stepped down from one
  a_r2_release_after_count: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n_q) |-> $past(cnt_q) == {{(CW-1){1'b0}}, 1'b1});

  // R6: a watchdog expiry reloads the full hold time
  a_r6_fire_reloads: assert property (@(posedge clk) disable iff (rst)
    wd_fire |=> (cnt_q == lim_rst) && !rst_n_q);

  // R3: both reset polarities always disagree
  a_r3_polarity: assert property (@(posedge clk) disable iff (rst)
    rst_q != rst_n_q);

endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog #(
  parameter int unsigned CW    = 12,
  parameter bit          WD_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          kick_lvl,
  input  logic          short_sel,
  input  logic          rst_active,
  input  logic [CW-1:0] lim_long,
  input  logic [CW-1:0] lim_short,
  output logic          fire_q
);

  generate
    if (WD_EN) begin : g_wd
      logic          kick_prev_q;
      logic          kick;
      logic          first_q;
      logic [CW-1:0] wcnt_q;
      logic [CW-1:0] lim;

      assign kick = kick_lvl ^ kick_prev_q;
      assign lim  = (first_q || !short_sel) ? lim_long : lim_short;

      always_ff @(posedge clk) begin
        if (rst) begin
          kick_prev_q <= 1'b0;
          first_q     <= 1'b1;
          wcnt_q      <= '0;
          fire_q      <= 1'b0;
        end else begin
          kick_prev_q <= kick_lvl;
          fire_q      <= 1'b0;
          if (rst_active) begin
            wcnt_q  <= '0;
            first_q <= 1'b1;
          end else if (kick) begin
            wcnt_q  <= '0;
            first_q <= 1'b0;
          end else if (step) begin
            if (wcnt_q >= lim - 1'b1) begin
              wcnt_q <= '0;
              fire_q <= 1'b1;
            end else begin
              wcnt_q <= wcnt_q + 1'b1;
            end
          end
        end
      end

      // R4: an expiry in the first period after reset counted the long limit
      a_r4_first_long: assert property (@(posedge clk) disable iff (rst)
        fire_q && $past(first_q) |-> $past(wcnt_q) == lim_long - 1'b1);

      // R5: a service edge always clears the count on the following edge
      a_r5_kick_clears: assert property (@(posedge clk) disable iff (rst)
        kick |=> wcnt_q == '0 && !fire_q);
    end else begin : g_nowd
      assign fire_q = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/sup_guard.sv
module sup_guard
  import sup_pkg::*;
#(
  parameter int unsigned RST_TICKS          = 200,
  parameter int unsigned WD_LONG_TICKS      = 1600,
  parameter int unsigned WD_SHORT_TICKS     = 100,
  parameter int unsigned EXT_RST_EDGES      = 1024,
  parameter int unsigned EXT_WD_LONG_EDGES  = 8192,
  parameter int unsigned EXT_WD_SHORT_EDGES = 512,
  parameter bit          WD_EN              = 1'b1,
  parameter int unsigned SYNC_STAGES        = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic ext_clk,
  input  logic clk_src_sel,
  input  logic supply_ok,
  input  logic batt_mode,
  input  logic pf_cmp,
  input  logic wd_kick,
  input  logic wd_short_sel,
  input  logic ce_in_n,
  output logic rst_n_out,
  output logic rst_out,
  output logic ce_out_n,
  output logic pf_out
);

  localparam int unsigned MAX_I = max_u(RST_TICKS, max_u(WD_LONG_TICKS, WD_SHORT_TICKS));
  localparam int unsigned MAX_E = max_u(EXT_RST_EDGES, max_u(EXT_WD_LONG_EDGES, EXT_WD_SHORT_EDGES));
  localparam int unsigned CW    = $clog2(max_u(MAX_I, MAX_E) + 1);
  localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1) << IX_SRC;

  logic [SYNC_W-1:0] raw;
  logic [SYNC_W-1:0] syn;
  logic              step;
  logic [CW-1:0]     lim_rst, lim_long, lim_short;
  logic              wd_fire;
  logic              rst_n_q, rst_q;
  logic              ce_q, pf_q;

  always_comb begin
    raw          = '0;
    raw[IX_SUP]  = supply_ok;
    raw[IX_BATT] = batt_mode;
    raw[IX_PF]   = pf_cmp;
    raw[IX_KICK] = wd_kick;
    raw[IX_EXT]  = ext_clk;
    raw[IX_SRC]  = clk_src_sel;
    raw[IX_SEL]  = wd_short_sel;
  end

  sup_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (syn)
  );

  sup_timebase #(
    .CW(CW), .RST_TICKS(RST_TICKS), .WD_LONG_TICKS(WD_LONG_TICKS),
    .WD_SHORT_TICKS(WD_SHORT_TICKS), .EXT_RST_EDGES(EXT_RST_EDGES),
    .EXT_WD_LONG_EDGES(EXT_WD_LONG_EDGES), .EXT_WD_SHORT_EDGES(EXT_WD_SHORT_EDGES)
  ) u_tb (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .ext_lvl   (syn[IX_EXT]),
    .src       (tsrc_e'(syn[IX_SRC])),
    .step      (step),
    .lim_rst   (lim_rst),
    .lim_long  (lim_long),
    .lim_short (lim_short)
  );

  sup_reset_gen #(.CW(CW)) u_rg (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .sup_ok  (syn[IX_SUP]),
    .wd_fire (wd_fire),
    .lim_rst (lim_rst),
    .rst_n_q (rst_n_q),
    .rst_q   (rst_q)
  );

  sup_watchdog #(.CW(CW), .WD_EN(WD_EN)) u_wd (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .kick_lvl   (syn[IX_KICK]),
    .short_sel  (syn[IX_SEL]),
    .rst_active (~rst_n_q),
    .lim_long   (lim_long),
    .lim_short  (lim_short),
    .fire_q     (wd_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q <= 1'b1;
      pf_q <= 1'b0;
    end else begin
      ce_q <= syn[IX_SUP] ? ce_in_n : 1'b1;
      pf_q <= syn[IX_PF] & ~syn[IX_BATT];
    end
  end

  assign rst_n_out = rst_n_q;
  assign rst_out   = rst_q;
  assign ce_out_n  = ce_q;
  assign pf_out    = pf_q;

  // R10: chip enable stays inactive while the supply is seen as bad
  a_r10_ce_forced: assert property (@(posedge clk) disable iff (rst)
    !syn[IX_SUP] |=> ce_out_n);

  // R11: battery mode drives the power-fail output low
  a_r11_batt_forces_low: assert property (@(posedge clk) disable iff (rst)
    syn[IX_BATT] |=> !pf_out);

endmodule

// File: tb/sup_guard_tb_top.sv
module sup_guard_tb_top;

  localparam int R  = 20;
  localparam int L  = 60;
  localparam int S  = 15;
  localparam int ER = 6;
  localparam int EL = 8;
  localparam int ES = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, tick = 1'b1, ext_clk = 1'b0, clk_src_sel = 1'b1;
  logic supply_ok = 1'b1, batt_mode = 1'b0, pf_cmp = 1'b1;
  logic wd_kick = 1'b0, wd_short_sel = 1'b1, ce_in_n = 1'b1;
  logic rst_n_out, rst_out, ce_out_n, pf_out;
  logic nw_rst_n, nw_rst, nw_ce, nw_pf;

  sup_guard #(.RST_TICKS(R), .WD_LONG_TICKS(L), .WD_SHORT_TICKS(S),
    .EXT_RST_EDGES(ER), .EXT_WD_LONG_EDGES(EL), .EXT_WD_SHORT_EDGES(ES),
    .WD_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .ext_clk(ext_clk), .clk_src_sel(clk_src_sel),
    .supply_ok(supply_ok), .batt_mode(batt_mode), .pf_cmp(pf_cmp), .wd_kick(wd_kick),
    .wd_short_sel(wd_short_sel), .ce_in_n(ce_in_n), .rst_n_out(rst_n_out),
    .rst_out(rst_out), .ce_out_n(ce_out_n), .pf_out(pf_out));

  sup_guard #(.RST_TICKS(R), .WD_LONG_TICKS(L), .WD_SHORT_TICKS(S),
    .EXT_RST_EDGES(ER), .EXT_WD_LONG_EDGES(EL), .EXT_WD_SHORT_EDGES(ES),
    .WD_EN(1'b0)) dut_nowd_i (
    .clk(clk), .rst(rst), .tick(tick), .ext_clk(ext_clk), .clk_src_sel(clk_src_sel),
    .supply_ok(supply_ok), .batt_mode(batt_mode), .pf_cmp(pf_cmp), .wd_kick(wd_kick),
    .wd_short_sel(wd_short_sel), .ce_in_n(ce_in_n), .rst_n_out(nw_rst_n),
    .rst_out(nw_rst), .ce_out_n(nw_ce), .pf_out(nw_pf));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  n_chk = 0;
  int  n_err = 0;
  bit  sb_on = 1'b1;
  logic prev_rn = 1'b0;

  typedef struct {
    int    at;
    logic  lvl;
    string req;
  } ev_t;
  ev_t evq[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_edge(input int at, input logic lvl, input string req);
    ev_t e;
    e.at = at; e.lvl = lvl; e.req = req;
    evq.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic ext_pulse();
    ext_clk = 1'b1; wait_n(4);
    ext_clk = 1'b0; wait_n(4);
  endtask

  // monitor: pops one expected edge for every change on the active-low reset
  always @(negedge clk) begin
    if (sb_on && rst_n_out !== prev_rn) begin
      if (evq.size() == 0) begin
        chk(1'b0, "R2 unexpected reset edge", cyc, -1);
      end else begin
        ev_t e;
        e = evq.pop_front();
        chk(e.at == cyc, e.req, cyc, e.at);
        chk(e.lvl === rst_n_out, e.req, int'(rst_n_out), int'(e.lvl));
        chk(rst_out === ~rst_n_out, "R3 polarity", int'(rst_out), int'(~rst_n_out));
      end
    end
    prev_rn = rst_n_out;
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog R2 run hung actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int c, t0, t1, t2, t3, t4, t5, t6, f, k;
    wait_n(3);
    // R12 reset state
    chk(rst_n_out == 1'b0, "R12 rst_n_out", int'(rst_n_out), 0);
    chk(rst_out == 1'b1, "R12 rst_out", int'(rst_out), 1);
    chk(ce_out_n == 1'b1, "R12 ce_out_n", int'(ce_out_n), 1);
    chk(pf_out == 1'b0, "R12 pf_out", int'(pf_out), 0);
    rst = 1'b0;
    c  = cyc;
    t0 = c + 2 + R;
    expect_edge(t0, 1'b1, "R2 power-on release");
    expect_edge(t0 + L + 1, 1'b0, "R4 first period long with short select");
    t1 = t0 + L + 1 + R;
    expect_edge(t1, 1'b1, "R6 full pulse");
    expect_edge(t1 + L + 1, 1'b0, "R6 repeat after long period");
    t2 = t1 + L + 1 + R;
    expect_edge(t2, 1'b1, "R6 full pulse again");

    // R11 power-fail output
    wait_n(4);
    chk(pf_out == 1'b1, "R11 follows comparator", int'(pf_out), 1);
    batt_mode = 1'b1; wait_n(4);
    chk(pf_out == 1'b0, "R11 battery forces low", int'(pf_out), 0);
    batt_mode = 1'b0; pf_cmp = 1'b0; wait_n(4);
    chk(pf_out == 1'b0, "R11 below threshold", int'(pf_out), 0);
    pf_cmp = 1'b1; wait_n(4);
    chk(pf_out == 1'b1, "R11 back above", int'(pf_out), 1);

    wait_cyc(t0 + L + 3);
    chk(nw_rst_n == 1'b1, "R7 disabled watchdog never fires", int'(nw_rst_n), 1);

    // R5 short period after a service edge
    wait_cyc(t2);
    wd_kick = ~wd_kick;
    f  = t2 + 3 + S + 1;
    expect_edge(f, 1'b0, "R5 short period after kick");
    t3 = f + R;
    expect_edge(t3, 1'b1, "R6 pulse after short expiry");

    // R5 regular service with long period selected
    wait_cyc(t3);
    wd_short_sel = 1'b0;
    wait_n(1);
    wd_kick = ~wd_kick;
    for (int i = 0; i < 7; i++) begin
      wait_n(40);
      wd_kick = ~wd_kick;
    end
    k = cyc;
    expect_edge(k + 3 + L + 1, 1'b0, "R5 long period with select low");
    t4 = k + 3 + L + 1 + R;
    expect_edge(t4, 1'b1, "R6 pulse after long expiry");

    // R10 chip enable, R1 supply drop, R2 brown-out restart
    wait_cyc(t4);
    chk(nw_rst_n == 1'b1, "R7 still no watchdog reset", int'(nw_rst_n), 1);
    ce_in_n = 1'b0; wait_n(1);
    chk(ce_out_n == 1'b0, "R10 copy low", int'(ce_out_n), 0);
    ce_in_n = 1'b1; wait_n(1);
    chk(ce_out_n == 1'b1, "R10 copy high", int'(ce_out_n), 1);
    ce_in_n = 1'b0; wait_n(1);
    supply_ok = 1'b0;
    c = cyc;
    expect_edge(c + 3, 1'b0, "R1 supply drop");
    wait_n(3);
    chk(ce_out_n == 1'b1, "R10 forced inactive", int'(ce_out_n), 1);
    wait_n(20);
    supply_ok = 1'b1; wait_n(10);
    supply_ok = 1'b0; wait_n(10);
    chk(rst_n_out == 1'b0, "R1 held during brown-out", int'(rst_n_out), 0);
    supply_ok = 1'b1;
    c  = cyc;
    t5 = c + 2 + R;
    expect_edge(t5, 1'b1, "R2 full time after last restore");
    wait_cyc(t5);
    chk(ce_out_n == 1'b0, "R10 copy restored", int'(ce_out_n), 0);

    // R9 tick held low freezes the hold counter
    tick = 1'b0;
    wait_n(2);
    supply_ok = 1'b0;
    c = cyc;
    expect_edge(c + 3, 1'b0, "R1 supply drop");
    wait_n(10);
    supply_ok = 1'b1;
    wait_n(100);
    chk(rst_n_out == 1'b0, "R9 frozen without ticks", int'(rst_n_out), 0);
    tick = 1'b1;
    t6 = cyc + R;
    expect_edge(t6, 1'b1, "R9 resumes on ticks");
    wait_cyc(t6);
    wait_n(2);
    supply_ok = 1'b0;
    c = cyc;
    expect_edge(c + 3, 1'b0, "R1 supply drop");
    wait_n(6);
    chk(evq.size() == 0, "R2 all expected edges seen", evq.size(), 0);
    sb_on = 1'b0;

    // R8 external clock edges with tick held high
    wd_short_sel = 1'b1;
    clk_src_sel  = 1'b0;
    wait_n(10);
    supply_ok = 1'b1;
    wait_n(6);
    repeat (ER - 1) ext_pulse();
    chk(rst_n_out == 1'b0, "R8 held before last edge", int'(rst_n_out), 0);
    ext_pulse();
    chk(rst_n_out == 1'b1, "R8 released after edge count", int'(rst_n_out), 1);
    repeat (EL - 1) ext_pulse();
    chk(rst_n_out == 1'b1, "R8 long period first in external mode", int'(rst_n_out), 1);
    ext_pulse();
    chk(rst_n_out == 1'b0, "R8 watchdog fires after long edge count", int'(rst_n_out), 0);
    chk(rst_out == 1'b1, "R3 polarity in external mode", int'(rst_out), 1);

    finish_run();
  end

endmodule